// File: doc/BRIEF.md
# Flash Access Protection Guard

This block sits on the data path between the processor and an on-chip flash array and enforces a protection policy keyed on where the executing instruction came from. A one-time-programmable lock bit decides whether protection exists at all. When it does, code fetched from anywhere other than flash cannot see the array contents: its flash reads return a fixed mask word. It also cannot start program, erase or status commands.

Protection is lifted only when code running from flash itself writes zero to an even flash address. It then stays off until the next command completes or the next reset, both of which re-arm it. Commands are requested with a one-cycle pulse. One cycle later the guard returns a response pulse carrying a two-bit status. An accepted command holds a busy flag until the programming engine signals completion.

Top module: `flash_guard`

## Requirements
- R1: After reset with the lock bit at 1, `prot_active` is 1, `cmd_busy` is 0 and `resp_valid` is 0.
- R2: With the lock bit at 0, `prot_active` is always 0. Reads from non-flash code return the array data, and commands are accepted with status 2'b00.
- R3: While `prot_active` is 1 and `fetch_in_flash` is 0, `rd_data` equals 0xB88B in the same cycle, whatever the array data.
- R4: While `prot_active` is 1 and `fetch_in_flash` is 1, `rd_data` equals `arr_rdata` in the same cycle.
- R5: A write with `fetch_in_flash` 1, `wr_data` zero and `wr_addr` bit 0 at 0 clears `prot_active` from the next cycle. After that, non-flash reads return the array data.
- R6: A zero write to an odd address, a non-zero write, or any write with `fetch_in_flash` 0 leaves `prot_active` unchanged.
- R7: A `cmd_req` while not busy and protected gives a one-cycle `resp_valid` pulse on the next cycle with `resp_status` 2'b01, and `cmd_busy` stays 0.
- R8: A `cmd_req` while not busy and unprotected gives a `resp_valid` pulse on the next cycle with `resp_status` 2'b00. `cmd_busy` is 1 from that cycle until the cycle after `cmd_done`.
- R9: A `cmd_done` while busy, with the lock bit at 1, makes `prot_active` 1 on the next cycle. This takes priority over a deprotect write in the same cycle.
- R10: A `cmd_req` while busy produces no response and leaves `cmd_busy` set. A `cmd_done` while not busy changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| otp_lock | input | 1 | One-time-programmable protection enable |
| fetch_in_flash | input | 1 | Current instruction was fetched from flash |
| arr_rdata | input | DW | Read data from the flash array |
| rd_data | output | DW | Read data after protection gating |
| wr_en | input | 1 | Data write to flash space |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | DW | Write data |
| cmd_req | input | 1 | Program/erase/status command request pulse |
| cmd_done | input | 1 | Command completion pulse from the engine |
| cmd_busy | output | 1 | An accepted command is in progress |
| resp_valid | output | 1 | Command response pulse |
| resp_status | output | 2 | 2'b00 accepted, 2'b01 refused (protected) |
| prot_active | output | 1 | Protection currently in force |

## Verification
The read gating is combinational, so `rd_data` is checked a moment after the inputs change, within the same cycle. Every other result comes from one register and is due one clock edge after the stimulus. These are the protection state change after a write or completion, the response pulse and status, and the busy flag. The bench drives inputs on the falling edge and samples at the next falling edge, one rising edge later. It also checks at a further falling edge that the response pulse has dropped.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [DW-1:0] MASK_WORD = 16'hB88B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          otp_lock,
  input  logic          fetch_in_flash,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cmd_req,
  input  logic          cmd_done,
  output logic          cmd_busy,
  output logic          resp_valid,
  output logic [1:0]    resp_status,
  output logic          prot_active
);
  localparam logic [1:0] ST_OK  = 2'b00;
  localparam logic [1:0] ST_PROT = 2'b01;

  logic prot_q;
  logic unlock_wr, finish, start;

  assign prot_active = prot_q & otp_lock;
  assign rd_data     = (prot_active && !fetch_in_flash) ? MASK_WORD : arr_rdata;
  assign unlock_wr   = wr_en & fetch_in_flash & ~wr_addr[0] & (wr_data == '0);
  assign finish      = cmd_busy & cmd_done;
  assign start       = cmd_req & ~cmd_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prot_q <= 1'b1;
    else if (finish)    prot_q <= 1'b1;
    else if (unlock_wr) prot_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_busy    <= 1'b0;
      resp_valid  <= 1'b0;
      resp_status <= ST_OK;
    end else begin
      resp_valid <= start;
      if (start) begin
        resp_status <= prot_active ? ST_PROT : ST_OK;
        cmd_busy    <= !prot_active;
      end else if (finish) begin
        cmd_busy <= 1'b0;
      end
    end
  end
endmodule

module flash_guard_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [DW-1:0] MASK_WORD = 16'hB88B
) (
  input logic          clk,
  input logic          rst_n,
  input logic          otp_lock,
  input logic          fetch_in_flash,
  input logic [DW-1:0] rd_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          cmd_req,
  input logic          cmd_done,
  input logic          cmd_busy,
  input logic          resp_valid,
  input logic [1:0]    resp_status,
  input logic          prot_active
);
  // R3
  mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_active && !fetch_in_flash) |-> rd_data == MASK_WORD);
  // R2
  unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !otp_lock |-> !prot_active);
  // R7
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_busy && prot_active) |=> (resp_valid && resp_status == 2'b01 && !cmd_busy));
  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_busy && !prot_active) |=> (resp_valid && resp_status == 2'b00 && cmd_busy));
  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && cmd_done && otp_lock) |=> (prot_active && !cmd_busy));
  // R5
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fetch_in_flash && !wr_addr[0] && wr_data == '0 && !(cmd_busy && cmd_done)) |=> !prot_active);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && !cmd_done) |=> (cmd_busy && !resp_valid));
endmodule

bind flash_guard flash_guard_chk #(.AW(AW), .DW(DW), .MASK_WORD(MASK_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .otp_lock(otp_lock), .fetch_in_flash(fetch_in_flash),
  .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cmd_req(cmd_req), .cmd_done(cmd_done), .cmd_busy(cmd_busy),
  .resp_valid(resp_valid), .resp_status(resp_status), .prot_active(prot_active)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;
  localparam logic [15:0] MASK = 16'hB88B;
  // {fetch_in_flash, arr_rdata, expected rd_data} while protected
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 16'h1234, MASK},
    {1'b1, 16'h1234, 16'h1234},
    {1'b0, 16'h0000, MASK},
    {1'b1, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'hB88B, MASK},
    {1'b1, 16'h0001, 16'h0001}
  };

  logic clk = 0, rst_n = 0, otp_lock = 1, fetch_in_flash = 0;
  logic [15:0] arr_rdata = 0, rd_data, wr_data = 0;
  logic [15:0] wr_addr = 0;
  logic wr_en = 0, cmd_req = 0, cmd_done = 0;
  logic cmd_busy, resp_valid, prot_active;
  logic [1:0] resp_status;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rst_n(rst_n), .otp_lock(otp_lock), .fetch_in_flash(fetch_in_flash),
    .arr_rdata(arr_rdata), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_req(cmd_req), .cmd_done(cmd_done), .cmd_busy(cmd_busy),
    .resp_valid(resp_valid), .resp_status(resp_status), .prot_active(prot_active)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic lock);
    otp_lock = lock;
    rst_n = 0;
    tick();
    rst_n = 1;
    tick();
  endtask

  task automatic write(input logic flash, input logic [15:0] a, input logic [15:0] d);
    fetch_in_flash = flash; wr_addr = a; wr_data = d; wr_en = 1;
    tick();
    wr_en = 0; fetch_in_flash = 0;
  endtask

  task automatic request();
    cmd_req = 1;
    tick();
    cmd_req = 0;
  endtask

  task automatic read(input string tag, input logic flash, input logic [15:0] d, input logic [15:0] exp);
    fetch_in_flash = flash; arr_rdata = d;
    #1;
    chk(tag, {16'h0, rd_data}, {16'h0, exp});
    fetch_in_flash = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset(1);
    chk("R1 prot", prot_active, 1);
    chk("R1 busy", cmd_busy, 0);
    chk("R1 resp", resp_valid, 0);

    for (int i = 0; i < 6; i++)
      read(VEC[i][32] ? "R4 flash read" : "R3 masked read", VEC[i][32], VEC[i][31:16], VEC[i][15:0]);

    request();
    chk("R7 resp", resp_valid, 1);
    chk("R7 status", resp_status, 2'b01);
    chk("R7 busy", cmd_busy, 0);
    tick();
    chk("R7 pulse end", resp_valid, 0);

    write(1, 16'h0011, 16'h0000);
    chk("R6 odd addr", prot_active, 1);
    write(1, 16'h0010, 16'h0004);
    chk("R6 nonzero", prot_active, 1);
    write(0, 16'h0010, 16'h0000);
    chk("R6 nonflash", prot_active, 1);
    read("R6 still masked", 0, 16'h5555, MASK);

    write(1, 16'h0020, 16'h0000);
    chk("R5 unlock", prot_active, 0);
    read("R5 true read", 0, 16'h5555, 16'h5555);

    request();
    chk("R8 resp", resp_valid, 1);
    chk("R8 status", resp_status, 2'b00);
    chk("R8 busy", cmd_busy, 1);
    request();
    chk("R10 no resp", resp_valid, 0);
    chk("R10 busy held", cmd_busy, 1);
    tick();
    chk("R8 busy waits", cmd_busy, 1);
    cmd_done = 1; tick(); cmd_done = 0;
    chk("R8 busy clear", cmd_busy, 0);
    chk("R9 rearm", prot_active, 1);
    read("R9 masked again", 0, 16'h2222, MASK);

    write(1, 16'h0000, 16'h0000);
    chk("R5 unlock again", prot_active, 0);
    request();
    chk("R8 busy2", cmd_busy, 1);
    fetch_in_flash = 1; wr_addr = 16'h0002; wr_data = 0; wr_en = 1; cmd_done = 1;
    tick();
    wr_en = 0; cmd_done = 0; fetch_in_flash = 0;
    chk("R9 priority", prot_active, 1);

    write(1, 16'h0004, 16'h0000);
    cmd_done = 1; tick(); cmd_done = 0;
    chk("R10 stray done", prot_active, 0);

    do_reset(1);
    chk("R1 reset rearm", prot_active, 1);

    do_reset(0);
    chk("R2 prot off", prot_active, 0);
    read("R2 true read", 0, 16'h7E7E, 16'h7E7E);
    request();
    chk("R2 status", resp_status, 2'b00);
    chk("R2 busy", cmd_busy, 1);
    cmd_done = 1; tick(); cmd_done = 0;
    chk("R2 after done", prot_active, 0);

    finish_run();
  end
endmodule